// File: doc/BRIEF.md
# Light-Load Burst Gate Controller

This block decides, cycle by cycle, whether a flyback power stage may switch. Two digital flags come from external comparators on the feedback voltage. One flag says the feedback is above the upper burst threshold, near 2.0 V. The other says it is below the lower burst threshold, near 1.6 V. Switching stops when feedback drops under the lower threshold and restarts when it climbs over the upper one. Between the two thresholds the previous decision is kept, so a hysteresis band separates the bursts.

While switching is enabled, the block also asserts a clamp enable that holds the peak current at or above a fixed floor, whatever the feedback level. Each burst therefore delivers more energy than the load needs, and feedback soon falls again.

A stop that lasts longer than a programmable number of time-base ticks (about 100 µs) moves the block into a standby state. There it raises a low-power flag for the supply-current control. The first crossing above the upper threshold leaves standby, drops the flag and resumes switching in normal mode. Both comparator flags are resynchronised with two flip-flops before use.

Top module: `burst_gate_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, the switching enable and the clamp enable are 1 and the low-power flag is 0.
- R2: With the below-lower flag at 1 and the above-upper flag at 0 while switching, the switching enable goes to 0.
- R3: With the above-upper flag at 1 while switching is stopped, the switching enable goes to 1.
- R4: With both flags at 0, the switching enable and the low-power flag keep their values for as long as that lasts.
- R5: The minimum-peak-current clamp enable equals the switching enable on every cycle.
- R6: After IDLE_TICKS tick pulses counted while switching is stopped and the below-lower flag stays at 1, the low-power flag goes to 1. The switching enable stays 0 while the flag is 1.
- R7: The idle tick count restarts from zero whenever the synchronised below-lower flag goes to 0.
- R8: In standby, the above-upper flag clears the low-power flag and sets the switching enable on the same clock edge.
- R9: When both flags are 1 at once, the above-upper flag takes priority and switching is enabled.
- R10: A flag change applied between two clock edges first shows at the outputs after the third rising edge. Two of those edges are spent in the synchroniser and one in the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fb_above_hi_i | input | 1 | Asynchronous flag: feedback above upper burst threshold |
| fb_below_lo_i | input | 1 | Asynchronous flag: feedback below lower burst threshold |
| tick_i | input | 1 | One-cycle time-base pulse for the standby entry timer |
| sw_en_o | output | 1 | Switching enable for the gate driver |
| min_pk_clamp_o | output | 1 | Enable for the minimum peak current floor |
| low_pwr_o | output | 1 | Low-current standby mode flag |

## Verification
The assertions check the following on every cycle:
- The clamp enable tracks the switching enable.
- Standby never coexists with switching.
- Every rise or fall of the switching enable is backed by the matching input flag three cycles earlier.
- Standby is entered only from a stopped state and is left only into switching.

The bench scenarios cover the timing-dependent parts:
- The exact three-edge latency.
- The hold inside the hysteresis band.
- Restarting the idle timer when feedback briefly leaves the low region.
- Eventual entry into standby after a long enough stop.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic [1:0] {
    ST_RUN     = 2'd0,
    ST_PAUSE   = 2'd1,
    ST_STANDBY = 2'd2
  } burst_state_e;
endpackage

// File: rtl/burst_sync.sv
module burst_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/burst_idle_timer.sv
module burst_idle_timer #(
  parameter int LIMIT = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic arm_i,
  input  logic tick_i,
  output logic expired_o
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM_C = CW'(LIMIT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !arm_i) begin
      cnt_q <= '0;
    end else if (tick_i && (cnt_q != LIM_C)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expired_o = (cnt_q == LIM_C);
endmodule

// File: rtl/burst_fsm.sv
module burst_fsm
  import burst_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         hi_s_i,
  input  logic         lo_s_i,
  input  logic         expired_i,
  output burst_state_e state_o,
  output logic         sw_en_o,
  output logic         clamp_o,
  output logic         low_pwr_o
);
  burst_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN: begin
        if (!hi_s_i && lo_s_i) state_d = ST_PAUSE;
      end
      ST_PAUSE: begin
        if (hi_s_i)                     state_d = ST_RUN;
        else if (lo_s_i && expired_i)   state_d = ST_STANDBY;
      end
      ST_STANDBY: begin
        if (hi_s_i) state_d = ST_RUN;
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_RUN;
      sw_en_o   <= 1'b1;
      clamp_o   <= 1'b1;
      low_pwr_o <= 1'b0;
    end else begin
      state_q   <= state_d;
      sw_en_o   <= (state_d == ST_RUN);
      clamp_o   <= (state_d == ST_RUN);
      low_pwr_o <= (state_d == ST_STANDBY);
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/burst_gate_ctrl.sv
module burst_gate_ctrl
  import burst_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int IDLE_TICKS  = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic fb_above_hi_i,
  input  logic fb_below_lo_i,
  input  logic tick_i,
  output logic sw_en_o,
  output logic min_pk_clamp_o,
  output logic low_pwr_o
);
  localparam int FLAGS = 2;

  logic [FLAGS-1:0] flags_s;
  logic             hi_s, lo_s, expired;
  burst_state_e     state;

  burst_sync #(.WIDTH(FLAGS), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i ({fb_above_hi_i, fb_below_lo_i}),
    .sync_o  (flags_s)
  );

  assign hi_s = flags_s[1];
  assign lo_s = flags_s[0];

  burst_idle_timer #(.LIMIT(IDLE_TICKS)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .arm_i     ((state == ST_PAUSE) && lo_s),
    .tick_i    (tick_i),
    .expired_o (expired)
  );

  burst_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .hi_s_i    (hi_s),
    .lo_s_i    (lo_s),
    .expired_i (expired),
    .state_o   (state),
    .sw_en_o   (sw_en_o),
    .clamp_o   (min_pk_clamp_o),
    .low_pwr_o (low_pwr_o)
  );
endmodule

// File: rtl/burst_gate_ctrl_chk.sv
module burst_gate_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic fb_above_hi_i,
  input logic fb_below_lo_i,
  input logic sw_en_o,
  input logic min_pk_clamp_o,
  input logic low_pwr_o
);
  assert_clamp_tracks_R5: assert property (@(posedge clk) disable iff (rst)
    min_pk_clamp_o == sw_en_o);

  assert_standby_gated_R6: assert property (@(posedge clk) disable iff (rst)
    low_pwr_o |-> !sw_en_o);

  assert_stop_cause_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(sw_en_o) |-> ($past(fb_below_lo_i, 3) && !$past(fb_above_hi_i, 3)));

  assert_resume_cause_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(sw_en_o) |-> $past(fb_above_hi_i, 3));

  assert_standby_entry_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(low_pwr_o) |-> !$past(sw_en_o));

  assert_standby_exit_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(low_pwr_o) |-> (sw_en_o && $past(fb_above_hi_i, 3)));
endmodule

bind burst_gate_ctrl burst_gate_ctrl_chk i_chk (
  .clk            (clk),
  .rst            (rst),
  .fb_above_hi_i  (fb_above_hi_i),
  .fb_below_lo_i  (fb_below_lo_i),
  .sw_en_o        (sw_en_o),
  .min_pk_clamp_o (min_pk_clamp_o),
  .low_pwr_o      (low_pwr_o)
);

// File: tb/test_burst_gate_ctrl.sv
module test_burst_gate_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int IDLE       = 10;
  localparam int TICK_DIV   = 4;

  typedef struct {
    logic  sw;
    logic  lp;
    string req;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hi  = 1'b0;
  logic lo  = 1'b0;
  logic tick = 1'b0;
  logic sw_en, clamp, low_pwr;

  int   n_checks = 0;
  int   n_fail   = 0;
  bit   finished = 1'b0;
  exp_t sb_q[$];
  event sample_ev;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_gate_ctrl #(.SYNC_STAGES(2), .IDLE_TICKS(IDLE)) i_burst_gate_ctrl (
    .clk            (clk),
    .rst            (rst),
    .fb_above_hi_i  (hi),
    .fb_below_lo_i  (lo),
    .tick_i         (tick),
    .sw_en_o        (sw_en),
    .min_pk_clamp_o (clamp),
    .low_pwr_o      (low_pwr)
  );

  // time base: one-cycle pulse every TICK_DIV cycles, driven at negedge
  initial begin
    forever begin
      for (int k = 0; k < TICK_DIV; k++) begin
        @(negedge clk);
        tick = (k == TICK_DIV - 1);
      end
    end
  end

  // monitor: pops expected items and compares with the outputs
  initial begin
    forever begin
      @(sample_ev);
      while (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        n_checks++;
        if (sw_en !== e.sw || clamp !== e.sw || low_pwr !== e.lp) begin
          n_fail++;
          $display("FAIL %s: sw_en=%0b clamp=%0b low_pwr=%0b expected sw_en=%0b clamp=%0b low_pwr=%0b",
                   e.req, sw_en, clamp, low_pwr, e.sw, e.sw, e.lp);
        end
      end
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_fb(input logic h, input logic l);
    hi = h;
    lo = l;
  endtask

  task automatic expect_out(input logic sw, input logic lp, input string req);
    exp_t e;
    e.sw = sw; e.lp = lp; e.req = req;
    sb_q.push_back(e);
    ->sample_ev;
    #1;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    finish_run();
  end

  initial begin
    @(negedge clk);
    expect_out(1'b1, 1'b0, "R1 during reset");
    wait_cyc(4);
    rst = 1'b0;
    wait_cyc(1);
    expect_out(1'b1, 1'b0, "R1 after reset");

    // hysteresis band while running
    wait_cyc(20);
    expect_out(1'b1, 1'b0, "R4 band hold while running");

    // stop with latency check
    set_fb(1'b0, 1'b1);
    wait_cyc(2);
    expect_out(1'b1, 1'b0, "R10 no change after two edges");
    wait_cyc(1);
    expect_out(1'b0, 1'b0, "R2 stop on below-lower");

    // short stop, then band hold
    wait_cyc(2 * TICK_DIV);
    set_fb(1'b0, 1'b0);
    wait_cyc(10);
    expect_out(1'b0, 1'b0, "R4 band hold while stopped");

    // resume
    set_fb(1'b1, 1'b0);
    wait_cyc(2);
    expect_out(1'b0, 1'b0, "R10 resume not yet visible");
    wait_cyc(1);
    expect_out(1'b1, 1'b0, "R3 resume on above-upper");

    // timer restart when feedback leaves low region
    set_fb(1'b0, 1'b0);
    wait_cyc(5);
    set_fb(1'b0, 1'b1);
    wait_cyc(3);
    expect_out(1'b0, 1'b0, "R2 stop again");
    wait_cyc((IDLE - 3) * TICK_DIV);
    set_fb(1'b0, 1'b0);
    wait_cyc(8);
    set_fb(1'b0, 1'b1);
    wait_cyc((IDLE - 3) * TICK_DIV);
    expect_out(1'b0, 1'b0, "R7 timer restarted by brief exit");
    wait_cyc((IDLE + 3) * TICK_DIV);
    expect_out(1'b0, 1'b1, "R6 standby after long stop");

    // standby held in band and while low
    set_fb(1'b0, 1'b0);
    wait_cyc(10);
    expect_out(1'b0, 1'b1, "R4 standby held in band");
    set_fb(1'b0, 1'b1);
    wait_cyc(10);
    expect_out(1'b0, 1'b1, "R6 standby held while low");

    // standby exit
    set_fb(1'b1, 1'b0);
    wait_cyc(2);
    expect_out(1'b0, 1'b1, "R10 standby exit not yet visible");
    wait_cyc(1);
    expect_out(1'b1, 1'b0, "R8 standby exit restarts switching");

    // fresh stop without long wait: no standby
    set_fb(1'b0, 1'b1);
    wait_cyc(3 + (IDLE - 2) * TICK_DIV);
    expect_out(1'b0, 1'b0, "R6 no standby before limit");

    // both flags: above-upper wins
    set_fb(1'b1, 1'b1);
    wait_cyc(3);
    expect_out(1'b1, 1'b0, "R9 both flags resume");
    wait_cyc((IDLE + 3) * TICK_DIV);
    expect_out(1'b1, 1'b0, "R9 both flags keep running");

    set_fb(1'b0, 1'b0);
    wait_cyc(5);
    if (sb_q.size() != 0) begin
      n_checks++;
      n_fail++;
      $display("FAIL scoreboard: pending=%0d expected=0", sb_q.size());
    end
    finish_run();
  end
endmodule